// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the ALU of a five-stage in-order pipeline. It decides where each of the two ALU operands of the instruction now in execute should come from. An older instruction may not yet have written its result back. It may be one stage ahead, holding its result in the execute/memory pipeline register, or two stages ahead, holding it in the memory/writeback register. In either case the block finds the read-after-write dependence by comparing register numbers. It then steers that operand to the newer value instead of the stale register-file read.

The selection is made separately for operand A and operand B. If both later stages will write the register being read, the instruction one stage ahead is the younger producer, so its value wins. A producer takes part only when its register-write flag is set. Register 0 is hard-wired to zero and is never bypassed. A writer that has already left writeback needs no path, because the register file handles a same-cycle write and read. The block also holds the two operand multiplexers, so it returns both the select codes and the chosen operand values. It is purely combinational. Load-use stalls are handled elsewhere.

Top module: `ex_bypass_unit`

## Requirements
- R1: When neither later stage writes the register an operand reads, that operand's select is 2'b00 (register file).
- R2: When the execute/memory producer has its write flag set, a destination other than 0, and a destination equal to an operand's source register, that operand's select is 2'b10.
- R3: When only the memory/writeback producer qualifies (write flag set, destination nonzero and equal to the source), that operand's select is 2'b01.
- R4: When both producers qualify for the same operand, the select is 2'b10, so the younger result wins.
- R5: A producer whose write flag is clear never causes forwarding, even if its destination number matches.
- R6: A source register number of 0 always gives select 2'b00, whatever the producers hold.
- R7: Operands A and B are resolved independently. When both read the same dependent register, both are forwarded.
- R8: Each operand output equals the register-file value for select 00, the execute/memory result for 10, and the memory/writeback result for 01.
- R9: The code 2'b11 never appears on either select output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | REG_W | Source register number for operand A of the instruction in execute |
| src_b | input | REG_W | Source register number for operand B of the instruction in execute |
| mem_wr | input | 1 | Register-write flag of the instruction in the execute/memory register |
| mem_rd | input | REG_W | Destination register of the instruction in the execute/memory register |
| wb_wr | input | 1 | Register-write flag of the instruction in the memory/writeback register |
| wb_rd | input | REG_W | Destination register of the instruction in the memory/writeback register |
| rf_a | input | DATA_W | Register-file read value for operand A |
| rf_b | input | DATA_W | Register-file read value for operand B |
| mem_res | input | DATA_W | Result held in the execute/memory register |
| wb_res | input | DATA_W | Result about to be written back from the memory/writeback register |
| sel_a | output | 2 | Operand A source code (00 register file, 10 execute/memory, 01 memory/writeback) |
| sel_b | output | 2 | Operand B source code, same encoding |
| opnd_a | output | DATA_W | Selected value for ALU operand A |
| opnd_b | output | DATA_W | Selected value for ALU operand B |

## Verification
The block has no registers, so every select code and operand value is due in the same cycle as the register numbers and data that produce it, with no latency. The bench applies each stimulus just after a rising clock edge and samples both selects and both operands at the following falling edge, after the inputs have settled and away from any edge. Each vector uses its own distinct data words on the four data inputs, so a wrong multiplexer leg is seen as a wrong value and not only as a wrong code.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Number of ALU operands resolved by the unit
    localparam int NOPND = 2;

    // Operand source encoding
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    // Younger producer has priority over the older one
    function automatic fwd_sel_e pick_source(input logic mem_hit, input logic wb_hit);
        if (mem_hit)
            return SEL_MEM;
        else if (wb_hit)
            return SEL_WB;
        else
            return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             wr,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);
    logic dst_live;

    // Register 0 is constant zero and never a real producer
    assign dst_live = wr && (dst != '0);
    assign hit      = dst_live && (dst == src);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output fwd_sel_e sel
);
    always_comb begin
        sel = pick_source(mem_hit, wb_hit);
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (sel)
            SEL_MEM: y = mem_val;
            SEL_WB:  y = wb_val;
            default: y = rf_val;
        endcase
    end
endmodule

// File: rtl/ex_bypass_unit.sv
module ex_bypass_unit
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic              mem_wr,
    input  logic [REG_W-1:0]  mem_rd,
    input  logic              wb_wr,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] mem_res,
    input  logic [DATA_W-1:0] wb_res,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    logic [REG_W-1:0]  src_v  [NOPND];
    logic [DATA_W-1:0] rf_v   [NOPND];
    logic [DATA_W-1:0] opnd_v [NOPND];
    fwd_sel_e          sel_v  [NOPND];
    logic              mem_hit[NOPND];
    logic              wb_hit [NOPND];

    assign src_v[0] = src_a;
    assign src_v[1] = src_b;
    assign rf_v[0]  = rf_a;
    assign rf_v[1]  = rf_b;

    // One identical, independent lane per ALU operand
    for (genvar g = 0; g < NOPND; g++) begin : g_lane
        fwd_match #(.REG_W(REG_W)) u_mem_cmp (
            .src (src_v[g]),
            .wr  (mem_wr),
            .dst (mem_rd),
            .hit (mem_hit[g])
        );

        fwd_match #(.REG_W(REG_W)) u_wb_cmp (
            .src (src_v[g]),
            .wr  (wb_wr),
            .dst (wb_rd),
            .hit (wb_hit[g])
        );

        fwd_pick u_pick (
            .mem_hit (mem_hit[g]),
            .wb_hit  (wb_hit[g]),
            .sel     (sel_v[g])
        );

        fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[g]),
            .rf_val  (rf_v[g]),
            .mem_val (mem_res),
            .wb_val  (wb_res),
            .y       (opnd_v[g])
        );
    end

    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];
    assign opnd_a = opnd_v[0];
    assign opnd_b = opnd_v[1];
endmodule

// File: rtl/ex_bypass_chk.sv
module ex_bypass_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_W-1:0]  src_a,
    input logic [REG_W-1:0]  src_b,
    input logic              mem_wr,
    input logic [REG_W-1:0]  mem_rd,
    input logic              wb_wr,
    input logic [REG_W-1:0]  wb_rd,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic [DATA_W-1:0] mem_res,
    input logic [DATA_W-1:0] wb_res,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);
    logic mem_a, mem_b, wb_a, wb_b;

    assign mem_a = mem_wr && (mem_rd == src_a) && (src_a != '0);
    assign mem_b = mem_wr && (mem_rd == src_b) && (src_b != '0);
    assign wb_a  = wb_wr  && (wb_rd  == src_a) && (src_a != '0);
    assign wb_b  = wb_wr  && (wb_rd  == src_b) && (src_b != '0);

    always_comb begin
        // R1
        rf_default_chk: assert ((mem_a || wb_a || sel_a == 2'b00) && (mem_b || wb_b || sel_b == 2'b00));
        // R2
        mem_fwd_chk: assert ((!mem_a || sel_a == 2'b10) && (!mem_b || sel_b == 2'b10));
        // R3
        wb_fwd_chk: assert ((mem_a || !wb_a || sel_a == 2'b01) && (mem_b || !wb_b || sel_b == 2'b01));
        // R5
        wr_gate_chk: assert ((mem_wr || sel_a != 2'b10) && (wb_wr || sel_a != 2'b01)
                             && (mem_wr || sel_b != 2'b10) && (wb_wr || sel_b != 2'b01));
        // R6
        zero_reg_chk: assert ((src_a != '0 || sel_a == 2'b00) && (src_b != '0 || sel_b == 2'b00));
        // R8
        opnd_data_chk: assert ((sel_a != 2'b00 || opnd_a == rf_a) && (sel_a != 2'b10 || opnd_a == mem_res)
                               && (sel_a != 2'b01 || opnd_a == wb_res) && (sel_b != 2'b00 || opnd_b == rf_b)
                               && (sel_b != 2'b10 || opnd_b == mem_res) && (sel_b != 2'b01 || opnd_b == wb_res));
        // R9
        legal_code_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
    end
endmodule

bind ex_bypass_unit ex_bypass_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ex_bypass_unit.sv
`timescale 1ns/1ps
module tb_ex_bypass_unit;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NVEC   = 10;
    localparam int VW     = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [REG_W-1:0]  src_a, src_b, mem_rd, wb_rd;
    logic              mem_wr, wb_wr;
    logic [DATA_W-1:0] rf_a, rf_b, mem_res, wb_res;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    int total = 0;
    int bad   = 0;

    ex_bypass_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) dut (
        .src_a(src_a), .src_b(src_b), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .wb_wr(wb_wr), .wb_rd(wb_rd), .rf_a(rf_a), .rf_b(rf_b),
        .mem_res(mem_res), .wb_res(wb_res), .sel_a(sel_a), .sel_b(sel_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Fields: src_a, src_b, mem_wr, mem_rd, wb_wr, wb_rd, expected sel_a, expected sel_b
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {5'd3,  5'd4,  1'b1, 5'd7,  1'b1, 5'd8,  2'b00, 2'b00},  // R1 no match
        {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd4,  2'b10, 2'b00},  // R2 / R5 on B
        {5'd3,  5'd4,  1'b0, 5'd3,  1'b1, 5'd4,  2'b00, 2'b01},  // R3 / R5 on A
        {5'd1,  5'd1,  1'b1, 5'd1,  1'b1, 5'd1,  2'b10, 2'b10},  // R4 / R7 same reg both
        {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},  // R6 register 0
        {5'd2,  5'd5,  1'b1, 5'd5,  1'b1, 5'd2,  2'b01, 2'b10},  // R7 crossed
        {5'd6,  5'd6,  1'b0, 5'd6,  1'b1, 5'd6,  2'b01, 2'b01},  // R5 / R3
        {5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 2'b10, 2'b10},  // R2 top register
        {5'd4,  5'd0,  1'b1, 5'd4,  1'b1, 5'd0,  2'b10, 2'b00},  // R6 on B
        {5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 5'd9,  2'b00, 2'b00}   // R5 both flags clear
    };

    task automatic chk_sel(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_dat(input string req, input string what, input logic [DATA_W-1:0] act,
                           input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pick(input logic [1:0] s, input logic [DATA_W-1:0] rf);
        case (s)
            2'b10:   return mem_res;
            2'b01:   return wb_res;
            default: return rf;
        endcase
    endfunction

    task automatic idle();
        src_a = '0; src_b = '0; mem_wr = 1'b0; mem_rd = '0; wb_wr = 1'b0; wb_rd = '0;
        rf_a = 32'h0000_00A0; rf_b = 32'h0000_00B0; mem_res = 32'h0000_00C0; wb_res = 32'h0000_00D0;
    endtask

    initial begin : watchdog
        repeat (10000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        idle();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle state after reset: register-file path on both operands
        chk_sel("R1", "idle sel_a", sel_a, 2'b00);
        chk_sel("R1", "idle sel_b", sel_b, 2'b00);
        chk_dat("R8", "idle opnd_a", opnd_a, 32'h0000_00A0);
        chk_dat("R8", "idle opnd_b", opnd_b, 32'h0000_00B0);

        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            {src_a, src_b, mem_wr, mem_rd, wb_wr, wb_rd} = VEC[i][VW-1:4];
            rf_a    = 32'h1100_0000 + i;
            rf_b    = 32'h2200_0000 + i;
            mem_res = 32'h3300_0000 + i;
            wb_res  = 32'h4400_0000 + i;
            @(negedge clk);
            // R2 R3 R4 R7 select codes per table
            chk_sel("R2/R3/R4", $sformatf("vec%0d sel_a", i), sel_a, VEC[i][3:2]);
            chk_sel("R7", $sformatf("vec%0d sel_b", i), sel_b, VEC[i][1:0]);
            // R8 operand values follow the expected code
            chk_dat("R8", $sformatf("vec%0d opnd_a", i), opnd_a, pick(VEC[i][3:2], rf_a));
            chk_dat("R8", $sformatf("vec%0d opnd_b", i), opnd_b, pick(VEC[i][1:0], rf_b));
            // R9 reserved code never seen
            total++;
            if (sel_a == 2'b11 || sel_b == 2'b11) begin
                bad++;
                $display("FAIL R9 vec%0d actual=%b/%b expected=not 11", i, sel_a, sel_b);
            end
        end

        // R5 matching destination but flag clear: stale producers ignored, data from register file
        @(posedge clk);
        idle();
        src_a = 5'd12; src_b = 5'd13; mem_rd = 5'd12; wb_rd = 5'd13;
        @(negedge clk);
        chk_dat("R5", "gated opnd_a", opnd_a, 32'h0000_00A0);
        chk_dat("R5", "gated opnd_b", opnd_b, 32'h0000_00B0);

        // R6 producer writing register 0 while operand reads register 0
        @(posedge clk);
        mem_wr = 1'b1; wb_wr = 1'b1; mem_rd = 5'd0; wb_rd = 5'd0; src_a = 5'd0; src_b = 5'd13;
        @(negedge clk);
        chk_sel("R6", "r0 sel_a", sel_a, 2'b00);
        chk_dat("R6", "r0 opnd_a", opnd_a, 32'h0000_00A0);

        // R4 double match, then the younger producer retires its flag: older one takes over
        @(posedge clk);
        src_a = 5'd20; src_b = 5'd20; mem_rd = 5'd20; wb_rd = 5'd20;
        @(negedge clk);
        chk_dat("R4", "double opnd_a", opnd_a, 32'h0000_00C0);
        @(posedge clk);
        mem_wr = 1'b0;
        @(negedge clk);
        chk_dat("R3", "fallback opnd_a", opnd_a, 32'h0000_00D0);
        chk_dat("R7", "fallback opnd_b", opnd_b, 32'h0000_00D0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule